// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder

This block recovers the information stream from a rate-1/2, constraint-length-3 convolutional code whose generators are 7 and 5 in octal. Each accepted cycle carries one pair of hard-decision coded bits, each a plain 0 or 1. After a fixed delay, the block returns one decoded bit per accepted pair. The internal flow has four steps. Hamming branch metrics are formed against the four possible code pairs. Add-compare-select updates four path metrics. One decision bit per state is written into a 16-deep survivor memory. A traceback then starts from the best state and releases the bit that is sixteen trellis steps old.

The trellis state is the pair of the two most recent input bits, `{newest, older}`. Input bit u from state s leads to state `{u, s[1]}`. The coded pair is `in_code[1] = u ^ s[1] ^ s[0]` (generator 7) and `in_code[0] = u ^ s[0]` (generator 5). A controlling state machine has two states. `S_FILL` is entered on reset and holds while the survivor window is not yet full. The transition `FILL_DONE` moves it to `S_RUN` when the sixteenth pair is accepted. `S_RUN` then holds (transition `RUN_HOLD`) until the next reset. Cycles with `in_valid` low are pure stalls.

Top module: `vit_dec`

## Requirements
- R1: While `rst` is high and in the cycle after, `out_valid` is 0, `out_bit` is 0 and the path metrics hold state 0 at 0 and the other three states at the start penalty.
- R2: The coded pair follows the convention above: state `{b[n-1], b[n-2]}`, `in_code[1]` from generator 7 (111) and `in_code[0]` from generator 5 (101). A stream encoded this way from the all-zero state decodes to its source bits.
- R3: With no channel errors, the k-th `out_bit` equals the k-th source bit for every source pattern (random, all ones, all zeros, alternating). A stream of N pairs yields exactly N-15 outputs.
- R4: A single flipped coded bit, with at least 20 steps to the next flip, is fully corrected.
- R5: Decoded bit k is presented with `out_valid` high exactly one clock cycle after the edge that accepts pair k+15. No output appears before the sixteenth accepted pair.
- R6: Cycles with `in_valid` low change neither the path metrics, the survivor write position nor `out_bit`, so idle gaps do not alter the decoded stream.
- R7: After each accepted pair the path metrics are normalised so that at least one state is 0 and none exceeds the start penalty plus 2, over arbitrarily long streams.
- R8: A reset in the middle of a stream discards all history; the next stream decodes as if from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_code` in this cycle |
| in_code | input | 2 | Hard coded pair; bit 1 from generator 7, bit 0 from generator 5 |
| out_valid | output | 1 | `out_bit` carries a newly decoded bit |
| out_bit | output | 1 | Decoded information bit, oldest first |

## Verification
The assertions assume three things about the input. The stream comes from an encoder that starts in the all-zero state when reset is released. The pairs are hard bits with no unknown values. Reset is held for at least one clock. The metric bound relies on the spread between states that any hard-decision [7 5] trellis produces, and this spread does not depend on how many errors the stream carries. The directed scenarios drive only pairs that the bench encodes from known source bits. Flips are placed at fixed spacing, and every new stream begins from a fresh reset, so the assumed start state always holds.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int NUM_STATES = 4;
    localparam int TB_DEPTH   = 16;
    localparam int PM_W       = 6;
    localparam int BM_W       = 2;
    localparam int PTR_W      = $clog2(TB_DEPTH);
    localparam int PENALTY    = 2 ** (PM_W - 2);

    typedef logic [PM_W-1:0]       pm_t;
    typedef logic [NUM_STATES-1:0] dec_t;
    typedef logic [1:0]            st_t;

    typedef enum logic {
        S_FILL,
        S_RUN
    } phase_e;
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu
    import vit_pkg::*;
#(
    parameter int W = BM_W
) (
    input  logic [1:0]        rx,
    output logic [3:0][W-1:0] bm
);
    for (genvar c = 0; c < 4; c++) begin : g_code
        localparam logic [1:0] CV = 2'(c);
        assign bm[c] = W'(rx[1] ^ CV[1]) + W'(rx[0] ^ CV[0]);
    end
endmodule

// File: rtl/vit_acs.sv
module vit_acs
    import vit_pkg::*;
#(
    parameter int NS = NUM_STATES,
    parameter int W  = PM_W,
    parameter int BW = BM_W,
    parameter int PEN = PENALTY
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic [3:0][BW-1:0]   bm,
    output logic [NS-1:0][W-1:0] pm_q,
    output logic [NS-1:0]        dec
);
    logic [NS-1:0][W-1:0] cand_a, cand_b, raw, norm;
    logic [W-1:0]         min_lo, min_hi, min_all;

    for (genvar j = 0; j < NS; j++) begin : g_state
        localparam int U     = j / 2;
        localparam int PA    = (j % 2) * 2;
        localparam int PB    = PA + 1;
        localparam int CODEA = 2 * (U ^ (PA / 2) ^ (PA % 2)) + (U ^ (PA % 2));
        localparam int CODEB = 2 * (U ^ (PB / 2) ^ (PB % 2)) + (U ^ (PB % 2));
        assign cand_a[j] = pm_q[PA] + W'(bm[CODEA]);
        assign cand_b[j] = pm_q[PB] + W'(bm[CODEB]);
        assign dec[j]    = (cand_b[j] < cand_a[j]);
        assign raw[j]    = dec[j] ? cand_b[j] : cand_a[j];
        assign norm[j]   = raw[j] - min_all;
    end

    always_comb begin
        min_lo  = (raw[1] < raw[0]) ? raw[1] : raw[0];
        min_hi  = (raw[3] < raw[2]) ? raw[3] : raw[2];
        min_all = (min_hi < min_lo) ? min_hi : min_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NS; s++) pm_q[s] <= (s == 0) ? '0 : W'(PEN);
        end else if (step) begin
            pm_q <= norm;
        end
    end

    // R1: metrics restart from the all-zero encoder state
    assert_reset_metrics_R1: assert property (@(posedge clk)
        rst |=> (pm_q[0] == '0 && pm_q[1] == W'(PEN) && pm_q[2] == W'(PEN) && pm_q[3] == W'(PEN)));

    // R7: no metric grows past the bounded spread
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (pm_q[0] <= W'(PEN + 2) && pm_q[1] <= W'(PEN + 2) &&
         pm_q[2] <= W'(PEN + 2) && pm_q[3] <= W'(PEN + 2)));

    // R7: normalisation leaves a zero-metric state after every step
    assert_min_zero_R7: assert property (@(posedge clk) disable iff (rst)
        $past(step) |-> (pm_q[0] == '0 || pm_q[1] == '0 || pm_q[2] == '0 || pm_q[3] == '0));

    // R6: idle cycles leave the metrics alone
    assert_metric_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pm_q));
endmodule

// File: rtl/vit_trace.sv
module vit_trace
    import vit_pkg::*;
#(
    parameter int NS    = NUM_STATES,
    parameter int W     = PM_W,
    parameter int DEPTH = TB_DEPTH,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic [NS-1:0]        dec,
    input  logic [NS-1:0][W-1:0] pm,
    output logic                 tb_bit
);
    logic [NS-1:0] mem [DEPTH];
    logic [PW-1:0] wp_q;
    logic [PW-1:0] rd_idx;
    st_t           best;
    logic [W-1:0]  best_pm;
    st_t           walk;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
        end else if (step) begin
            mem[wp_q] <= dec;
            wp_q      <= wp_q + 1'b1;
        end
    end

    always_comb begin
        best    = '0;
        best_pm = pm[0];
        for (int s = 1; s < NS; s++) begin
            if (pm[s] < best_pm) begin
                best    = st_t'(s);
                best_pm = pm[s];
            end
        end
    end

    always_comb begin
        walk   = best;
        rd_idx = '0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            rd_idx = wp_q - PW'(i + 1);
            walk   = {walk[0], mem[rd_idx][walk]};
        end
        tb_bit = walk[1];
    end

    // R6: the survivor write position only moves on accepted pairs
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(wp_q));

    // R5: the window advances one slot per step and wraps in binary
    assert_ptr_advance_R5: assert property (@(posedge clk) disable iff (rst)
        step |=> (wp_q == $past(wp_q) + 1'b1));
endmodule

// File: rtl/vit_dec.sv
module vit_dec
    import vit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [1:0] in_code,
    output logic       out_valid,
    output logic       out_bit
);
    logic [3:0][BM_W-1:0]         bm;
    logic [NUM_STATES-1:0][PM_W-1:0] pm;
    logic [NUM_STATES-1:0]        dec;
    logic                         tb_bit;
    logic                         step_q;
    logic [PTR_W-1:0]             fill_q;
    phase_e                       phase_q, phase_d;

    vit_bmu #(.W(BM_W)) i_bmu (
        .rx (in_code),
        .bm (bm)
    );

    vit_acs #(.NS(NUM_STATES), .W(PM_W), .BW(BM_W), .PEN(PENALTY)) i_acs (
        .clk  (clk),
        .rst  (rst),
        .step (in_valid),
        .bm   (bm),
        .pm_q (pm),
        .dec  (dec)
    );

    vit_trace #(.NS(NUM_STATES), .W(PM_W), .DEPTH(TB_DEPTH), .PW(PTR_W)) i_trace (
        .clk    (clk),
        .rst    (rst),
        .step   (in_valid),
        .dec    (dec),
        .pm     (pm),
        .tb_bit (tb_bit)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            S_FILL: if (in_valid && fill_q == PTR_W'(TB_DEPTH - 1)) phase_d = S_RUN;
            S_RUN:  phase_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= S_FILL;
            fill_q  <= '0;
            step_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            step_q  <= in_valid;
            if (in_valid && phase_q == S_FILL) fill_q <= fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= step_q && (phase_q == S_RUN);
            if (step_q && phase_q == S_RUN) out_bit <= tb_bit;
        end
    end

    // R5: every output is paid for by a pair accepted two edges earlier
    assert_out_follows_input_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R5: nothing leaves while the window is still filling
    assert_fill_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == S_FILL) |=> !out_valid);

    // R6: the held output only changes together with a valid strobe
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_bit));
endmodule

// File: tb/test_vit_dec.sv
module test_vit_dec;
    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_code = 2'b00;
    logic       out_valid;
    logic       out_bit;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    int  n_in = 0;
    int  n_out = 0;
    bit  ref_bits [MAXN];
    int  acc_cyc  [MAXN];
    logic [1:0] enc_st = 2'b00;

    vit_dec i_vit_dec (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Output monitor: R3/R4 bit values, R5 timing
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (n_out + 15 < MAXN) begin
                check(out_bit == ref_bits[n_out], "R3", $sformatf("bit %0d value", n_out),
                      int'(out_bit), int'(ref_bits[n_out]));
                check(cyc == acc_cyc[n_out + 15] + 1, "R5", $sformatf("bit %0d cycle", n_out),
                      cyc, acc_cyc[n_out + 15] + 1);
            end
            n_out++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_bit == 1'b0, "R1", "out_bit in reset", int'(out_bit), 0);
        rst = 1'b0;
        n_in = 0;
        n_out = 0;
        enc_st = 2'b00;
    endtask

    task automatic send(input bit u, input bit f1, input bit f0);
        logic c1, c0;
        c1 = u ^ enc_st[1] ^ enc_st[0];
        c0 = u ^ enc_st[0];
        enc_st = {u, enc_st[1]};
        @(negedge clk);
        in_valid = 1'b1;
        in_code = {c1 ^ f1, c0 ^ f0};
        ref_bits[n_in] = u;
        acc_cyc[n_in] = cyc + 1;
        n_in++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_code = 2'b00;
        end
    endtask

    task automatic finish_stream(input string req);
        idle(4);
        check(n_out == n_in - 15, req, "output count", n_out, n_in - 15);
    endtask

    task automatic t_reset_and_fill();
        do_reset();
        idle(1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        for (int i = 0; i < 15; i++) send(1'(i % 3 == 0), 1'b0, 1'b0);
        idle(3);
        check(n_out == 0, "R5", "no output before 16th pair", n_out, 0);
        send(1'b1, 1'b0, 1'b0);
        idle(3);
        check(n_out == 1, "R5", "first output after 16th pair", n_out, 1);
    endtask

    task automatic t_clean_random();
        do_reset();
        for (int i = 0; i < 300; i++) send(1'($urandom), 1'b0, 1'b0);
        finish_stream("R3");
    endtask

    task automatic t_patterns();
        do_reset();
        for (int i = 0; i < 60; i++) send(1'b1, 1'b0, 1'b0);
        finish_stream("R2");
        do_reset();
        for (int i = 0; i < 60; i++) send(1'(i % 2), 1'b0, 1'b0);
        finish_stream("R2");
        do_reset();
        for (int i = 0; i < 60; i++) send(1'b0, 1'b0, 1'b0);
        finish_stream("R3");
        do_reset();
        for (int i = 0; i < 60; i++) send(1'((i / 3) % 2), 1'b0, 1'b0);
        finish_stream("R3");
    endtask

    task automatic t_isolated_flips();
        do_reset();
        for (int i = 0; i < 400; i++) begin
            bit fl;
            fl = (i % 20 == 7);
            send(1'($urandom), fl & 1'((i / 20) % 2), fl & 1'(((i / 20) + 1) % 2));
        end
        finish_stream("R4");
    endtask

    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 200; i++) begin
            send(1'($urandom), 1'b0, 1'b0);
            idle(int'($urandom % 4));
        end
        finish_stream("R6");
    endtask

    task automatic t_restart();
        do_reset();
        for (int i = 0; i < 40; i++) send(1'($urandom), 1'b0, 1'b0);
        do_reset();
        for (int i = 0; i < 100; i++) send(1'($urandom), 1'b0, 1'b0);
        finish_stream("R8");
    endtask

    task automatic t_long_normalise();
        do_reset();
        for (int i = 0; i < 2000; i++) begin
            bit fl;
            fl = (i % 25 == 12);
            send(1'($urandom), fl, 1'b0);
        end
        finish_stream("R7");
    endtask

    initial begin
        t_reset_and_fill();
        t_clean_random();
        t_patterns();
        t_isolated_flips();
        t_gaps();
        t_restart();
        t_long_normalise();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule